// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Interval Timer

This block is a timekeeping peripheral built on a wide free-running counter. The counter splits into a low portion of `LO_W` bits and a high portion of `HI_W` bits, 32 and 8 by default. Each portion can be read as its own register word. The counter advances by one on every clock cycle where the `tick_en` input is high.

An alarm comparator watches the full counter value. A separate down-counting interval timer reloads itself from a programmable value. Three sticky interrupt flags report the following events:
- the full counter wrapping around;
- the counter reaching the alarm target;
- the interval timer expiring.

Software uses a single-cycle register port with combinational read data. Through this port it sets up the control word, the alarm target and the interval reload value. It reads the counter words and clears the flags. The control word has these fields:
- separate hold bits for the high counter portion, the low counter portion and the interval timer;
- an enable for the interval timer;
- a clear bit that pins the counter at zero.

Top module: `rtc_timer`

## Requirements
- R1: After reset every register word (addresses 0 to 7) reads zero and all three interrupt outputs are low.
- R2: Each cycle with `tick_en` high raises the counter by one. The low portion reads at address 1 and the high portion at address 2, with unused upper bits reading zero. With `tick_en` low the counter holds.
- R3: The control word at address 0 has three hold bits. Bit 1 holds the high portion; a carry out of the low portion during that time is dropped. Bit 2 holds the low portion, and therefore the whole counter. Bit 3 holds the interval timer.
- R4: Control bit 4 forces the counter to zero and keeps it there whatever `tick_en` does. After the bit is cleared, counting resumes from zero.
- R5: The alarm target is written as a low word (address 3) and a high word (address 4). Only the low `HI_W` bits of the high word are stored, read back and compared.
- R6: When the counter advances onto a value equal to the alarm target, status bit 30 and `irq_alarm` become set in the same cycle that the new count is visible.
- R7: The interval timer is enabled by control bit 0 and takes its reload value R from address 5. Once enabled, it sets status bit 29 and `irq_period` on every (R+1)-th tick.
- R8: When the full counter wraps from all ones to zero, status bit 31 and `irq_wrap` become set.
- R9: Status is at address 6. Writing a one to bits 31, 30 or 29 clears that flag. A flag that is set and cleared in the same cycle stays set.
- R10: While control bit 0 is low the interval timer neither counts nor fires. Changing the bit from 0 to 1 reloads the timer from the reload register.
- R11: Writing zero to the control word leaves all hold, clear and enable bits off. The counter then counts and the interval timer stays idle.
- R12: While `tick_en` is low, repeated reads of the counter words return identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for the counter and the interval timer |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_wrap | output | 1 | Sticky counter wrap flag |
| irq_alarm | output | 1 | Sticky alarm match flag |
| irq_period | output | 1 | Sticky interval expiry flag |

## Verification
The bench runs a narrow configuration (8+4 counter bits) through every counter value and its wrap, comparing each value read back with the number of ticks applied. A lost carry or an off-by-one increment shows up at the first mismatch. A compare that ignores the masking of the alarm high word would either never fire or fire at the wrong count.

The interval timer is swept over several reload values and every tick is checked. A timer that fires every R ticks instead of R+1 is caught. So is one that keeps its stale count across a disable and re-enable, because it would fire early.

A flag cleared in the same cycle that it is set must stay high. If the clear wins, the flag reads back low.

A high-portion hold must drop the carry. A design that drops the carry only after a delay would show a high word of one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALM_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALM_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd6;

  // status flag positions, index 0..2 maps to bit 31..29
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_TOP  = 31;
  localparam int unsigned FL_WRAP   = 0;
  localparam int unsigned FL_ALARM  = 1;
  localparam int unsigned FL_PERIOD = 2;

  localparam int unsigned CTRL_W = 5;

  typedef struct packed {
    logic zero_cnt;   // bit 4
    logic hold_per;   // bit 3
    logic hold_lo;    // bit 2
    logic hold_hi;    // bit 1
    logic per_on;     // bit 0
  } ctrl_t;

endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 8,
  localparam int unsigned FULL_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_lo,
  input  logic              hold_hi,
  input  logic              zero_cnt,
  input  logic [FULL_W-1:0] target,
  output logic [LO_W-1:0]   lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic              wrap_evt,
  output logic              match_evt
);

  logic            lo_step, hi_step;
  logic [LO_W-1:0] lo_d;
  logic [HI_W-1:0] hi_d;

  always_comb begin
    lo_step   = tick & ~hold_lo & ~zero_cnt;
    hi_step   = lo_step & (&lo_q) & ~hold_hi;
    lo_d      = lo_q;
    hi_d      = hi_q;
    if (zero_cnt) begin
      lo_d = '0;
      hi_d = '0;
    end else begin
      if (lo_step) lo_d = lo_q + LO_W'(1);
      if (hi_step) hi_d = hi_q + HI_W'(1);
    end
    wrap_evt  = hi_step & (&hi_q);
    match_evt = lo_step & ({hi_d, lo_d} == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt |=> (lo_q == '0) && (hi_q == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !zero_cnt) |=> ($stable(lo_q) && $stable(hi_q)));
  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_lo && !zero_cnt) |=> ($stable(lo_q) && $stable(hi_q)));
  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_hi && !zero_cnt) |=> $stable(hi_q));
  p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (lo_q == '0) && (hi_q == '0));

endmodule

// File: rtl/rtc_interval.sv
module rtc_interval #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             hold,
  input  logic             load,
  input  logic [PER_W-1:0] reload,
  output logic             fire
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             run;

  always_comb begin
    run   = enable & ~hold & tick & ~load;
    fire  = run & (cnt_q == '0);
    cnt_d = cnt_q;
    if (load)
      cnt_d = reload;
    else if (run)
      cnt_d = (cnt_q == '0) ? reload : cnt_q - PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_fire_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == $past(reload)));
  p_load_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload)));
  p_off_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(cnt_q));
  p_frozen_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_flag.sv
module rtc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic d;

  always_comb d = set | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && clr) |=> !q);

endmodule

// File: rtl/rtc_timer.sv
module rtc_timer #(
  parameter int unsigned LO_W  = 32,
  parameter int unsigned HI_W  = 8,
  parameter int unsigned PER_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_wrap,
  output logic        irq_alarm,
  output logic        irq_period
);
  import rtc_pkg::*;

  localparam int unsigned FULL_W = LO_W + HI_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [LO_W-1:0]  alm_lo_q, alm_lo_d;
  logic [HI_W-1:0]  alm_hi_q, alm_hi_d;
  logic [PER_W-1:0] rel_q, rel_d;

  logic [LO_W-1:0]  cnt_lo;
  logic [HI_W-1:0]  cnt_hi;
  logic             wrap_evt, match_evt, per_fire, per_load;
  logic             wr_ctrl, wr_stat;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;

  // register write decode
  always_comb begin
    wr_ctrl  = wr_en && (addr == A_CTRL);
    wr_stat  = wr_en && (addr == A_STATUS);
    ctrl_d   = ctrl_q;
    alm_lo_d = alm_lo_q;
    alm_hi_d = alm_hi_q;
    rel_d    = rel_q;
    if (wr_ctrl)                        ctrl_d   = ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr_en && addr == A_ALM_LO)      alm_lo_d = wdata[LO_W-1:0];
    if (wr_en && addr == A_ALM_HI)      alm_hi_d = wdata[HI_W-1:0];
    if (wr_en && addr == A_RELOAD)      rel_d    = wdata[PER_W-1:0];
    per_load = wr_ctrl & wdata[0] & ~ctrl_q.per_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      alm_lo_q <= '0;
      alm_hi_q <= '0;
      rel_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      alm_lo_q <= alm_lo_d;
      alm_hi_q <= alm_hi_d;
      rel_q    <= rel_d;
    end
  end

  rtc_count #(.LO_W(LO_W), .HI_W(HI_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .hold_lo  (ctrl_q.hold_lo),
    .hold_hi  (ctrl_q.hold_hi),
    .zero_cnt (ctrl_q.zero_cnt),
    .target   ({alm_hi_q, alm_lo_q}),
    .lo_q     (cnt_lo),
    .hi_q     (cnt_hi),
    .wrap_evt (wrap_evt),
    .match_evt(match_evt)
  );

  rtc_interval #(.PER_W(PER_W)) u_interval (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_en),
    .enable (ctrl_q.per_on),
    .hold   (ctrl_q.hold_per),
    .load   (per_load),
    .reload (rel_q),
    .fire   (per_fire)
  );

  always_comb begin
    fl_set[FL_WRAP]   = wrap_evt;
    fl_set[FL_ALARM]  = match_evt;
    fl_set[FL_PERIOD] = per_fire;
  end

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    assign fl_clr[gi] = wr_stat & wdata[FLAG_TOP - gi];
    rtc_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (fl_set[gi]),
      .clr  (fl_clr[gi]),
      .q    (fl_q[gi])
    );
  end

  assign irq_wrap   = fl_q[FL_WRAP];
  assign irq_alarm  = fl_q[FL_ALARM];
  assign irq_period = fl_q[FL_PERIOD];

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_CNT_LO: rdata[LO_W-1:0]   = cnt_lo;
      A_CNT_HI: rdata[HI_W-1:0]   = cnt_hi;
      A_ALM_LO: rdata[LO_W-1:0]   = alm_lo_q;
      A_ALM_HI: rdata[HI_W-1:0]   = alm_hi_q;
      A_RELOAD: rdata[PER_W-1:0]  = rel_q;
      A_STATUS: for (int i = 0; i < NUM_FLAGS; i++) rdata[FLAG_TOP - i] = fl_q[i];
      default:  rdata = '0;
    endcase
  end

  p_alarm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> irq_alarm && ({cnt_hi, cnt_lo} == FULL_W'({alm_hi_q, alm_lo_q})));
  p_wrap_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> irq_wrap);
  p_ctrl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && wdata == 32'd0) |=> (ctrl_q == '0));
  p_per_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_fire |=> irq_period);

endmodule

// File: tb/rtc_timer_tb.sv
module rtc_timer_tb;
  localparam int LO = 8;
  localparam int HI = 4;
  localparam int PW = 8;
  localparam int FULL = 1 << (LO + HI);

  logic        clk = 1'b0;
  logic        rst_n, tick_en, wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_wrap, irq_alarm, irq_period;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  rtc_timer #(.LO_W(LO), .HI_W(HI), .PER_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_wrap(irq_wrap), .irq_alarm(irq_alarm), .irq_period(irq_period)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic run(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irqs", {29'd0, irq_wrap, irq_alarm, irq_period}, 0);

    // R5 alarm high masking
    wr(3'd4, 32'hFFFF_FFF5);
    rd(3'd4, v); chk("R5 alarm hi mask", v, 32'h5);

    // R12 / R2 stable while idle
    run(7);
    rd(3'd1, v); repeat (3) @(negedge clk); rd(3'd1, v2);
    chk("R12 stable lo", v2, v);
    chk("R2 count 7", v, 7);

    // R4 clear holds zero then resumes
    wr(3'd0, 32'h10); run(5);
    rd(3'd1, v); chk("R4 held zero", v, 0);
    wr(3'd0, 32'h0); run(3);
    rd(3'd1, v); chk("R4 resumes", v, 3);

    // R3 high hold drops carry
    wr(3'd0, 32'h10); wr(3'd0, 32'h0);
    run(255);
    wr(3'd0, 32'h2); run(1);
    rd(3'd1, v); chk("R3 lo after carry", v, 0);
    rd(3'd2, v); chk("R3 hi held", v, 0);
    wr(3'd0, 32'h0); run(256);
    rd(3'd2, v); chk("R3 hi after release", v, 1);
    // R3 low hold freezes whole counter
    wr(3'd0, 32'h4); run(10);
    rd(3'd1, v); chk("R3 lo held", v, 0);
    rd(3'd2, v); chk("R3 hi held by lo", v, 1);

    // R11 control write of zero
    wr(3'd0, 32'h1F); wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R11 ctrl zero", v, 0);
    rd(3'd1, v2); run(4); rd(3'd1, v);
    chk("R11 counts", v, v2 + 4);

    // R7 interval sweep over reload values
    for (int r = 0; r < 5; r++) begin
      wr(3'd0, 32'h0);
      wr(3'd5, 32'(r));
      wr(3'd6, 32'hE000_0000);
      wr(3'd0, 32'h1);
      for (int i = 1; i <= 3 * (r + 1); i++) begin
        run(1);
        rd(3'd6, v);
        chk("R7 period flag", {31'd0, v[29]}, (i % (r + 1) == 0) ? 1 : 0);
        chk("R7 irq_period", {31'd0, irq_period}, (i % (r + 1) == 0) ? 1 : 0);
        wr(3'd6, 32'h2000_0000);
      end
    end

    // R10 disable halts, re-enable reloads
    wr(3'd0, 32'h0); wr(3'd5, 32'd4); wr(3'd6, 32'hE000_0000);
    wr(3'd0, 32'h1); run(2);
    wr(3'd0, 32'h0); run(6);
    chk("R10 idle no fire", {31'd0, irq_period}, 0);
    wr(3'd0, 32'h1); run(4);
    chk("R10 reload not early", {31'd0, irq_period}, 0);
    run(1);
    chk("R10 fires after reload", {31'd0, irq_period}, 1);

    // R3 interval hold
    wr(3'd6, 32'h2000_0000);
    wr(3'd0, 32'h9); run(12);
    chk("R3 interval held", {31'd0, irq_period}, 0);

    // R9 set beats clear in the same cycle
    wr(3'd0, 32'h0); wr(3'd5, 32'd0); wr(3'd0, 32'h1);
    tick_en = 1'b1;
    wr(3'd6, 32'h2000_0000);
    tick_en = 1'b0;
    rd(3'd6, v); chk("R9 set wins", {31'd0, v[29]}, 1);
    wr(3'd6, 32'h2000_0000);
    rd(3'd6, v); chk("R9 w1c clears", {31'd0, v[29]}, 0);
    wr(3'd0, 32'h0);

    // R2 / R6 / R8 full sweep with alarm target 0x5A3
    wr(3'd3, 32'hFFFF_FFA3);
    wr(3'd4, 32'h00AB_CDE5);
    wr(3'd0, 32'h10); wr(3'd0, 32'h0);
    wr(3'd6, 32'hE000_0000);
    for (int k = 1; k <= FULL; k++) begin
      run(1);
      rd(3'd1, v);  chk("R2 sweep lo", v, 32'((k % FULL) & 8'hFF));
      rd(3'd2, v2); chk("R2 sweep hi", v2, 32'((k % FULL) >> 8));
      chk("R6 alarm", {31'd0, irq_alarm}, (k >= 32'h5A3) ? 1 : 0);
      chk("R8 wrap", {31'd0, irq_wrap}, (k == FULL) ? 1 : 0);
    end
    rd(3'd6, v); chk("R8 status word", v, 32'hC000_0000);
    wr(3'd6, 32'h8000_0000);
    rd(3'd6, v); chk("R9 clear one flag", v, 32'h4000_0000);

    report();
  end

endmodule